// File: doc/BRIEF.md
# Dual-Mode Time-Slot Interchange Buffer

This block is the switching memory of a time-division channel switch. Incoming channel bytes arrive one at a time, each tagged with its channel number. They are written into a two-bank data store, with one bank per frame. An output consumer asks for an output channel number, and the block answers one cycle later with the byte routed to that channel. The route comes from a connection map. Each entry of the map gives a source channel, an enable and a transfer mode.

Two markers drive the timing. A frame pulse swaps the banks and clears the count of finished slots. A slot-boundary pulse marks the end of each 2 Mb/s slot. A constant-delay output always reads the bank of the previous frame, so all bytes of a multi-slot wideband channel keep their frame alignment. A minimum-delay output reads the current frame as soon as its source slot has ended, and reads the previous frame otherwise. A register port writes the map into a staging copy, and the frame pulse makes that copy live.

Top module: `tsi_buffer`

## Requirements
- R1: After reset, `out_valid` is 0 and every output channel is disabled, so any request returns 0xFF until a configured map has been made live by a frame pulse.
- R2: A request asserted on `out_req` in one cycle produces `out_valid`=1 in the next cycle, with `out_ochan` equal to the requested channel. No `out_valid` appears without a request.
- R3: A request for an output channel whose live map entry has enable=0 returns 0xFF.
- R4: An enabled output with mode bit 0 (constant delay) returns the byte that its source channel received in the previous frame, even after the source slot of the current frame has ended.
- R5: An enabled output with mode bit 1 (minimum delay) returns the current frame's byte when the source channel number is less than the number of slot-boundary pulses seen since the last frame pulse.
- R6: An enabled output with mode bit 1 returns the previous frame's byte while its source slot has not yet ended in the current frame.
- R7: A map write stays invisible at the outputs until the next frame pulse. From that pulse on, the new entry is used.
- R8: Each frame pulse swaps the banks. Data written in frame k is read by constant-delay outputs during frame k+1 and is replaced by frame k+1 data after the following pulse.
- R9: A frame pulse resets the finished-slot count to 0. The count then rises by one for each slot pulse and saturates at the channel count.
- R10: Several output channels may name the same source, and each of them receives that source's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame pulse: bank swap, slot count clear, map activation |
| slot_i | input | 1 | End-of-slot pulse at the 2 Mb/s slot rate |
| in_valid | input | 1 | Input byte strobe |
| in_chan | input | CW | Channel number of the input byte |
| in_byte | input | 8 | Input byte |
| out_req | input | 1 | Output read request |
| out_chan | input | CW | Output channel being requested |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_ochan | output | CW | Output channel of the result |
| out_byte | output | 8 | Routed byte, or 0xFF when the channel is disabled |
| cfg_we | input | 1 | Map write strobe (goes to the staging copy) |
| cfg_addr | input | CW | Output channel whose entry is written |
| cfg_src | input | CW | Source channel of the entry |
| cfg_en | input | 1 | Enable of the entry |
| cfg_mode | input | 1 | Transfer mode: 0 constant delay, 1 minimum delay |

## Verification
The bench builds the block with NCH=8, so CW is 3. At that size the bench can fill every slot of several frames explicitly. It can drive the finished-slot count across all source positions, which brings both sides of the minimum-delay decision into reach for early and late sources. It also makes stale data from two frames back distinguishable from the previous frame's data across three consecutive bank swaps.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Largest supported channel count is 512, so source fields are 9 bits.
    localparam int MAX_CW = 9;
    localparam int XW     = MAX_CW + 1;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef enum logic {
        XFER_CONST = 1'b0,
        XFER_MIN   = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic              en;
        xfer_mode_e        mode;
        logic [MAX_CW-1:0] src;
    } map_entry_t;

    // Minimum-delay outputs see the live bank once their source slot has ended.
    function automatic logic read_live_bank(map_entry_t e, logic [XW-1:0] slots_done);
        return (e.mode == XFER_MIN) && (XW'(e.src) < slots_done);
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
    parameter int NCH = 64,
    localparam int SW = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_i,
    input  logic          slot_i,
    output logic          wr_bank,
    output logic [SW-1:0] slots_done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank    <= 1'b0;
            slots_done <= '0;
        end else if (frame_i) begin
            wr_bank    <= ~wr_bank;
            slots_done <= '0;
        end else if (slot_i && (slots_done != SW'(NCH))) begin
            slots_done <= slots_done + 1'b1;
        end
    end

    p_bank_swap_r8: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (wr_bank != $past(wr_bank)));

    p_frame_clear_r9: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (slots_done == '0));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        slots_done <= SW'(NCH));

endmodule

// File: rtl/tsi_map.sv
module tsi_map
    import tsi_pkg::*;
#(
    parameter int NCH = 64,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_i,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_addr,
    input  map_entry_t    cfg_entry,
    input  logic [CW-1:0] rd_addr,
    output map_entry_t    rd_entry
);

    map_entry_t staged [NCH];
    map_entry_t live   [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[i] <= '0;
                live[i]   <= '0;
            end else begin
                if (cfg_we && (cfg_addr == CW'(i)))
                    staged[i] <= cfg_entry;
                if (frame_i)
                    live[i] <= staged[i];
            end
        end

        // Live entries change only at a frame pulse.
        p_live_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !frame_i |=> $stable(live[i]));
    end

    assign rd_entry = live[rd_addr];

endmodule

// File: rtl/tsi_store.sv
module tsi_store #(
    parameter int NCH = 64,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_bank,
    input  logic [CW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [CW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [2*NCH];

    always_ff @(posedge clk) begin
        if (we)
            mem[{wr_bank, wr_addr}] <= wr_data;
    end

    assign rd_data = mem[{rd_bank, rd_addr}];

endmodule

// File: rtl/tsi_buffer.sv
module tsi_buffer
    import tsi_pkg::*;
#(
    parameter int NCH = 64,
    localparam int CW = $clog2(NCH),
    localparam int SW = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_i,
    input  logic          slot_i,
    input  logic          in_valid,
    input  logic [CW-1:0] in_chan,
    input  logic [7:0]    in_byte,
    input  logic          out_req,
    input  logic [CW-1:0] out_chan,
    output logic          out_valid,
    output logic [CW-1:0] out_ochan,
    output logic [7:0]    out_byte,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_src,
    input  logic          cfg_en,
    input  logic          cfg_mode
);

    logic          wr_bank;
    logic [SW-1:0] slots_done;
    map_entry_t    cfg_entry;
    map_entry_t    route;
    logic          use_live;
    logic          rd_bank;
    logic [7:0]    rd_data;

    tsi_timing #(.NCH(NCH)) u_timing (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame_i),
        .slot_i     (slot_i),
        .wr_bank    (wr_bank),
        .slots_done (slots_done)
    );

    always_comb begin
        cfg_entry      = '0;
        cfg_entry.en   = cfg_en;
        cfg_entry.mode = xfer_mode_e'(cfg_mode);
        cfg_entry.src  = MAX_CW'(cfg_src);
    end

    tsi_map #(.NCH(NCH)) u_map (
        .clk       (clk),
        .rst       (rst),
        .frame_i   (frame_i),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_entry (cfg_entry),
        .rd_addr   (out_chan),
        .rd_entry  (route)
    );

    // Live bank for finished minimum-delay sources, previous bank otherwise.
    assign use_live = read_live_bank(route, XW'(slots_done));
    assign rd_bank  = use_live ? wr_bank : ~wr_bank;

    tsi_store #(.NCH(NCH), .DW(8)) u_store (
        .clk     (clk),
        .we      (in_valid),
        .wr_bank (wr_bank),
        .wr_addr (in_chan),
        .wr_data (in_byte),
        .rd_bank (rd_bank),
        .rd_addr (route.src[CW-1:0]),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ochan <= '0;
            out_byte  <= IDLE_BYTE;
        end else begin
            out_valid <= out_req;
            if (out_req) begin
                out_ochan <= out_chan;
                out_byte  <= route.en ? rd_data : IDLE_BYTE;
            end
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        out_req |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !out_req |=> !out_valid);

    p_chan_echo_r2: assert property (@(posedge clk) disable iff (rst)
        out_req |=> (out_ochan == $past(out_chan)));

    p_idle_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (out_req && !route.en) |=> (out_byte == IDLE_BYTE));

endmodule

// File: tb/tsi_buffer_bench.sv
module tsi_buffer_bench;

    localparam int NCH = 8;
    localparam int CW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_i = 1'b0, slot_i = 1'b0, in_valid = 1'b0, out_req = 1'b0;
    logic [CW-1:0] in_chan = '0, out_chan = '0, cfg_addr = '0, cfg_src = '0;
    logic [7:0]    in_byte = '0;
    logic          cfg_we = 1'b0, cfg_en = 1'b0, cfg_mode = 1'b0;
    logic          out_valid;
    logic [CW-1:0] out_ochan;
    logic [7:0]    out_byte;

    always #2 clk = ~clk;

    tsi_buffer #(.NCH(NCH)) u_tsi_buffer (
        .clk(clk), .rst(rst), .frame_i(frame_i), .slot_i(slot_i),
        .in_valid(in_valid), .in_chan(in_chan), .in_byte(in_byte),
        .out_req(out_req), .out_chan(out_chan),
        .out_valid(out_valid), .out_ochan(out_ochan), .out_byte(out_byte),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_src(cfg_src),
        .cfg_en(cfg_en), .cfg_mode(cfg_mode)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model built from the requirements.
    logic [7:0] prev_b [NCH];
    logic [7:0] cur_b  [NCH];
    int         done_m = 0;
    int         fnum   = 0;
    bit         st_en [NCH], lv_en [NCH];
    bit         st_md [NCH], lv_md [NCH];
    int         st_src[NCH], lv_src[NCH];

    // Scoreboard queues.
    logic [7:0] exp_q [$];
    int         ch_q  [$];
    string      tag_q [$];

    function automatic logic [7:0] byte_of(int f, int ch);
        return 8'((f * 37 + ch * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] expect_for(int o);
        if (!lv_en[o]) return 8'hFF;
        if (lv_md[o] && (lv_src[o] < done_m)) return cur_b[lv_src[o]];
        return prev_b[lv_src[o]];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_frame();
        frame_i = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            prev_b[i] = cur_b[i];
            lv_en[i] = st_en[i]; lv_md[i] = st_md[i]; lv_src[i] = st_src[i];
        end
        done_m = 0;
        fnum++;
        tick();
        frame_i = 1'b0;
    endtask

    task automatic put_slot(int s);
        in_valid = 1'b1; in_chan = CW'(s); in_byte = byte_of(fnum, s);
        cur_b[s] = byte_of(fnum, s);
        tick();
        in_valid = 1'b0;
        slot_i = 1'b1;
        if (done_m < NCH) done_m++;
        tick();
        slot_i = 1'b0;
    endtask

    task automatic set_map(int o, int src, bit en, bit md);
        cfg_we = 1'b1; cfg_addr = CW'(o); cfg_src = CW'(src); cfg_en = en; cfg_mode = md;
        st_en[o] = en; st_md[o] = md; st_src[o] = src;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic request(int o, string tag);
        exp_q.push_back(expect_for(o));
        ch_q.push_back(o);
        tag_q.push_back(tag);
        out_req = 1'b1; out_chan = CW'(o);
        tick();
        out_req = 1'b0;
    endtask

    // Monitor: compare each produced result with the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 32'(out_valid), 32'(0));
            end else begin
                logic [7:0] e;
                int c;
                string t;
                e = exp_q.pop_front();
                c = ch_q.pop_front();
                t = tag_q.pop_front();
                check({t, " byte"}, 32'(out_byte), 32'(e));
                check("R2 channel echo", 32'(out_ochan), 32'(c));
            end
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            st_en[i] = 0; st_md[i] = 0; st_src[i] = 0;
            lv_en[i] = 0; lv_md[i] = 0; lv_src[i] = 0;
            prev_b[i] = '0; cur_b[i] = '0;
        end
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 out_valid after reset", 32'(out_valid), 32'(0));
        request(0, "R1 disabled after reset");

        set_map(0, 3, 1, 0);
        set_map(1, 2, 1, 1);
        set_map(2, 6, 1, 1);
        set_map(3, 0, 0, 0);
        set_map(4, 3, 1, 0);
        set_map(5, 0, 1, 1);
        request(1, "R7 staged entry not live");

        do_frame();                                // frame 1: fill
        for (int s = 0; s < NCH; s++) put_slot(s);

        do_frame();                                // frame 2
        request(0, "R4 constant delay previous frame");
        request(1, "R6 min delay source pending");
        request(5, "R9 count cleared at frame");
        request(3, "R3 disabled output");
        request(4, "R10 shared source");
        put_slot(0);
        request(5, "R5 min delay source finished");
        put_slot(1);
        put_slot(2);
        request(1, "R5 min delay after slot 2");
        request(0, "R4 constant before source slot");
        put_slot(3);
        request(0, "R4 constant after source slot");
        request(2, "R6 min delay late source");
        set_map(3, 1, 1, 1);
        request(3, "R7 write mid-frame has no effect");
        for (int s = 4; s < NCH; s++) put_slot(s);
        slot_i = 1'b1; tick(); slot_i = 1'b0;     // extra pulse: count saturates
        request(2, "R5 min delay last source");

        do_frame();                                // frame 3
        request(3, "R7 entry live after frame");
        request(0, "R8 previous frame after swap");
        for (int s = 0; s < NCH; s++) put_slot(s);
        request(3, "R5 new entry min delay");

        do_frame();                                // frame 4
        request(0, "R8 data replaced after second swap");
        request(4, "R10 shared source later frame");
        tick();
        tick();
        check("R2 all results delivered", 32'(exp_q.size()), 32'(0));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule